// File: doc/BRIEF.md
# Clock Domain Enable Generator

This block turns one of four root clock sources into a set of clock-enable strobes, one per clock domain of a small microcontroller. Everything runs on a single fast reference clock. Each root source is presented as a tick input, high in the reference cycles where that source has an edge. The generator never gates a clock. Each domain receives an enable that is high in the reference cycles where that domain advances.

The selected source tick is the system tick. The NVM access enable divides the system tick by the slow-down ratio, and only while slow-down is switched on. The CPU enable divides the NVM access enable further by the NVM factor. The two peripheral enables and the NVM peripheral enable follow the CPU enable. The communication/timer enable takes the system tick undivided, so serial links and their timers keep their rate in slow-down. A filter tick comes from a programmable prescaler, and software sets it near 2 MHz.

A power-down request stops every domain enable. The filter tick then keeps running from the low-precision source. A wake-up request restarts all domains except the primary peripheral domain, which waits for the PLL-lock input. New settings for source, slow-down and NVM factor are taken only at the common boundary of all dividers.

Top module: `clk_domain_ctrl`

## Requirements
- R1: `src_sel` picks the system tick from `src_tick`: index 0 is the PLL, 1 the external oscillator, 2 the internal oscillator and 3 the low-precision clock. Without division, `en_comm` and `en_nvmacc` follow the selected tick.
- R2: While `slow_en` is 0, the `slow_div` field has no effect and the slow-down ratio is 1.
- R3: While `slow_en` is 1, `en_nvmacc` pulses once every 2^`slow_div` system ticks (values 0 to 7 give ratios 1 to 128).
- R4: `en_cpu` pulses once every (`nvm_fac`+1) pulses of `en_nvmacc` (values 0 to 3 give ratios 1 to 4). Every `en_cpu` pulse coincides with an `en_nvmacc` pulse.
- R5: In run state, `en_pclk`, `en_pclk2` and `en_nvmclk` are identical to `en_cpu`.
- R6: `en_comm` equals the system tick whatever the values of `slow_en`, `slow_div` and `nvm_fac`.
- R7: Changes of `src_sel`, `slow_en`, `slow_div` and `nvm_fac` take effect only after the system tick on which the common divider phase wraps, so no enable interval is ever shortened.
- R8: After `pd_req` is seen in run state, every domain enable stays low. `filt_tick` keeps counting ticks of source 3.
- R9: After `wake_req` is seen in power-down, all domain enables except `en_pclk` resume from the next cycle. `en_pclk` stays low until `pll_lock` has been seen high, and resumes in the cycle after that.
- R10: `filt_tick` pulses once every (`filt_pre`+1) base ticks. The base tick is the system tick, or the source 3 tick during power-down.
- R11: With both ratios at 1 and a system tick that is always high, every domain enable is constantly high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | Edge ticks of the four root sources |
| src_sel | input | 2 | Root source select |
| slow_en | input | 1 | Slow-down enable |
| slow_div | input | SLOW_W | Slow-down ratio exponent |
| nvm_fac | input | FAC_W | NVM-to-CPU factor minus one |
| filt_pre | input | FILT_W | Filter prescaler period minus one |
| pd_req | input | 1 | Power-down request |
| wake_req | input | 1 | Wake-up request |
| pll_lock | input | 1 | PLL locked indication |
| en_nvmacc | output | 1 | NVM access domain enable |
| en_cpu | output | 1 | CPU domain enable |
| en_pclk | output | 1 | Primary peripheral domain enable |
| en_pclk2 | output | 1 | Secondary peripheral domain enable |
| en_nvmclk | output | 1 | NVM peripheral domain enable |
| en_comm | output | 1 | Communication/timer domain enable |
| filt_tick | output | 1 | Filter tick |

## Verification
A wrong shadow register or a wrong wrap point in the divider shows up within one full divider period. The NVM access or CPU pulse count over a window then differs from the window length divided by the programmed ratio. Settings loaded at the wrong moment show up as an enable pulse inside the first old-length interval after a change, which a cycle-by-cycle check finds. A bad power-state register shows up in the first cycle after a request: an enable stays high in power-down, or the primary peripheral enable appears before the PLL-lock input is high.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_DOWN = 2'd1,
      PS_WAKE = 2'd2
   } pwr_state_e;

   localparam int SRC_COUNT = 4;
   localparam int SRC_LOWP  = 3;

endpackage

// File: rtl/ccu_pwr_seq.sv
module ccu_pwr_seq
   import ccu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pd_req,
   input  logic       wake_req,
   input  logic       pll_lock,
   output pwr_state_e state,
   output logic       core_run,
   output logic       pclk_run
);

   pwr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_RUN:  if (pd_req) state_d = PS_DOWN;
         PS_DOWN: if (wake_req) state_d = PS_WAKE;
         PS_WAKE: begin
            if (pd_req)        state_d = PS_DOWN;
            else if (pll_lock) state_d = PS_RUN;
         end
         default: state_d = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_RUN;
      else        state_q <= state_d;
   end

   assign state    = state_q;
   assign core_run = (state_q != PS_DOWN);
   assign pclk_run = (state_q == PS_RUN);

   // R9: run is only re-entered from wake after lock was seen
   p_lock_before_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_RUN && $past(state_q) == PS_WAKE) |-> $past(pll_lock));

   // R8: power-down is entered only on request
   p_down_on_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_DOWN && $past(state_q) != PS_DOWN) |-> $past(pd_req));

endmodule

// File: rtl/ccu_ratio_div.sv
module ccu_ratio_div #(
   parameter int SLOW_W = 3,
   parameter int FAC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_tick,
   input  logic              hold,
   input  logic [1:0]        src_sel,
   input  logic              slow_en,
   input  logic [SLOW_W-1:0] slow_div,
   input  logic [FAC_W-1:0]  nvm_fac,
   output logic [1:0]        src_sel_q,
   output logic              nvm_pulse,
   output logic              cpu_pulse
);

   localparam int CNT_W = FAC_W + (1 << SLOW_W) - 1;
   localparam int LW    = CNT_W + 1;

   logic [SLOW_W-1:0] shift_q;
   logic [FAC_W-1:0]  fac_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LW-1:0]     span;
   logic [LW-1:0]     last;
   logic [CNT_W-1:0]  smask;
   logic              wrap;
   logic              load;

   assign span  = (LW'(fac_q) + LW'(1)) << shift_q;
   assign last  = span - LW'(1);
   assign smask = CNT_W'((LW'(1) << shift_q) - LW'(1));
   assign wrap  = (cnt_q == last[CNT_W-1:0]);
   assign load  = hold | (sys_tick & wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q   <= '0;
         fac_q     <= '0;
         src_sel_q <= '0;
         cnt_q     <= '0;
      end else begin
         if (load) begin
            shift_q   <= slow_en ? slow_div : '0;
            fac_q     <= nvm_fac;
            src_sel_q <= src_sel;
            cnt_q     <= '0;
         end else if (sys_tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign nvm_pulse = sys_tick && ((cnt_q & smask) == '0);
   assign cpu_pulse = sys_tick && (cnt_q == '0);

   // R7: ratio settings only change right after a boundary or a hold
   p_load_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(shift_q) || !$stable(fac_q) || !$stable(src_sel_q)) |-> $past(load));

   // R4: the phase counter never passes the programmed span
   p_phase_in_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
      LW'(cnt_q) <= last);

endmodule

// File: rtl/ccu_filt_presc.sv
module ccu_filt_presc #(
   parameter int FILT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic [FILT_W-1:0] pre,
   output logic              tick
);

   logic [FILT_W-1:0] fcnt_q;
   logic              at_end;

   assign at_end = (fcnt_q >= pre);
   assign tick   = base_tick && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fcnt_q <= '0;
      else if (base_tick) fcnt_q <= at_end ? '0 : fcnt_q + FILT_W'(1);
   end

   // R10: the prescaler restarts after every filter tick
   p_filt_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick) |-> (fcnt_q == '0));

endmodule

// File: rtl/clk_domain_ctrl.sv
module clk_domain_ctrl
   import ccu_pkg::*;
#(
   parameter int SLOW_W = 3,
   parameter int FAC_W  = 2,
   parameter int FILT_W = 6
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic [3:0]        src_tick,
   input  logic [1:0]        src_sel,
   input  logic              slow_en,
   input  logic [SLOW_W-1:0] slow_div,
   input  logic [FAC_W-1:0]  nvm_fac,
   input  logic [FILT_W-1:0] filt_pre,
   input  logic              pd_req,
   input  logic              wake_req,
   input  logic              pll_lock,
   output logic              en_nvmacc,
   output logic              en_cpu,
   output logic              en_pclk,
   output logic              en_pclk2,
   output logic              en_nvmclk,
   output logic              en_comm,
   output logic              filt_tick
);

   localparam int NPER = 3;
   localparam logic [NPER-1:0] LOCK_GATED = 3'b001;

   if (SLOW_W < 1 || SLOW_W > 4) begin : g_bad_slow
      $error("SLOW_W must lie in 1..4");
   end
   if (FAC_W < 1 || FAC_W > 4) begin : g_bad_fac
      $error("FAC_W must lie in 1..4");
   end
   if (FILT_W < 1 || FILT_W > 16) begin : g_bad_filt
      $error("FILT_W must lie in 1..16");
   end

   pwr_state_e      pwr_state;
   logic            core_run;
   logic            pclk_run;
   logic [1:0]      sel_q;
   logic            sys_tick;
   logic            nvm_pulse;
   logic            cpu_pulse;
   logic            filt_base;
   logic            in_down;
   logic [NPER-1:0] per_en;

   ccu_pwr_seq u_pwr (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .pd_req   (pd_req),
      .wake_req (wake_req),
      .pll_lock (pll_lock),
      .state    (pwr_state),
      .core_run (core_run),
      .pclk_run (pclk_run)
   );

   assign in_down  = (pwr_state == PS_DOWN);
   assign sys_tick = src_tick[sel_q];

   ccu_ratio_div #(.SLOW_W(SLOW_W), .FAC_W(FAC_W)) u_div (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .sys_tick  (sys_tick),
      .hold      (in_down),
      .src_sel   (src_sel),
      .slow_en   (slow_en),
      .slow_div  (slow_div),
      .nvm_fac   (nvm_fac),
      .src_sel_q (sel_q),
      .nvm_pulse (nvm_pulse),
      .cpu_pulse (cpu_pulse)
   );

   assign filt_base = in_down ? src_tick[SRC_LOWP] : sys_tick;

   ccu_filt_presc #(.FILT_W(FILT_W)) u_filt (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .base_tick (filt_base),
      .pre       (filt_pre),
      .tick      (filt_tick)
   );

   for (genvar i = 0; i < NPER; i++) begin : g_per
      if (LOCK_GATED[i]) begin : g_lock
         assign per_en[i] = cpu_pulse & pclk_run;
      end else begin : g_core
         assign per_en[i] = cpu_pulse & core_run;
      end
   end

   assign en_nvmacc = nvm_pulse & core_run;
   assign en_cpu    = cpu_pulse & core_run;
   assign en_comm   = sys_tick  & core_run;
   assign en_pclk   = per_en[0];
   assign en_pclk2  = per_en[1];
   assign en_nvmclk = per_en[2];

   // R8: no domain enable in power-down
   p_down_quiet_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      in_down |-> !(en_nvmacc | en_cpu | en_pclk | en_pclk2 | en_nvmclk | en_comm));

   // R4: CPU pulses land on NVM access pulses
   p_cpu_on_nvm_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      en_cpu |-> en_nvmacc);

   // R6: communication domain is never slower than the CPU domain
   p_comm_not_slower_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      en_cpu |-> en_comm);

   // R9: primary peripheral enable only after a lock was seen in wake
   p_pclk_after_lock_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (en_pclk && $past(pwr_state) == PS_WAKE) |-> $past(pll_lock));

endmodule

// File: tb/sim_clk_domain_ctrl.sv
module sim_clk_domain_ctrl;

   logic       clk_ref = 1'b0;
   logic       rst_n   = 1'b0;
   logic [3:0] src_tick = 4'b0001;
   logic [1:0] src_sel  = 2'd0;
   logic       slow_en  = 1'b0;
   logic [2:0] slow_div = 3'd0;
   logic [1:0] nvm_fac  = 2'd0;
   logic [5:0] filt_pre = 6'd0;
   logic       pd_req   = 1'b0;
   logic       wake_req = 1'b0;
   logic       pll_lock = 1'b1;
   logic       en_nvmacc, en_cpu, en_pclk, en_pclk2, en_nvmclk, en_comm, filt_tick;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;
   int acc[7];

   always #5 clk_ref = ~clk_ref;

   clk_domain_ctrl u0 (
      .clk_ref(clk_ref), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
      .slow_en(slow_en), .slow_div(slow_div), .nvm_fac(nvm_fac), .filt_pre(filt_pre),
      .pd_req(pd_req), .wake_req(wake_req), .pll_lock(pll_lock),
      .en_nvmacc(en_nvmacc), .en_cpu(en_cpu), .en_pclk(en_pclk), .en_pclk2(en_pclk2),
      .en_nvmclk(en_nvmclk), .en_comm(en_comm), .filt_tick(filt_tick)
   );

   // source ticks: periods 1, 2, 3 and 5 reference cycles
   initial begin
      int bc = 0;
      forever begin
         @(posedge clk_ref); #1;
         bc++;
         src_tick = {bc % 5 == 0, bc % 3 == 0, bc % 2 == 0, 1'b1};
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk_ref);
      #1;
   endtask

   // index: 0 nvmacc 1 cpu 2 pclk 3 pclk2 4 nvmclk 5 comm 6 filt
   task automatic measure(input int n);
      for (int k = 0; k < 7; k++) acc[k] = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk_ref);
         acc[0] += int'(en_nvmacc); acc[1] += int'(en_cpu);
         acc[2] += int'(en_pclk);   acc[3] += int'(en_pclk2);
         acc[4] += int'(en_nvmclk); acc[5] += int'(en_comm);
         acc[6] += int'(filt_tick);
      end
      step(1);
   endtask

   task automatic t_reset;
      @(negedge clk_ref);
      check("R11 reset cpu", int'(en_cpu), 1);
      check("R11 reset pclk", int'(en_pclk), 1);
      check("R11 reset nvmacc", int'(en_nvmacc), 1);
   endtask

   task automatic t_source;
      int per[4] = '{1, 2, 3, 5};
      for (int s = 0; s < 4; s++) begin
         src_sel = 2'(s);
         step(20);
         measure(60);
         check($sformatf("R1 comm src%0d", s), acc[5], 60 / per[s]);
         check($sformatf("R1 nvmacc src%0d", s), acc[0], 60 / per[s]);
      end
      src_sel = 2'd0;
      step(20);
   endtask

   task automatic t_ratio(input bit se, input int sd, input int nf);
      int s, l;
      slow_en = se; slow_div = 3'(sd); nvm_fac = 2'(nf);
      s = se ? (1 << sd) : 1;
      l = s * (nf + 1);
      step(600);
      measure(1536);
      if (!se) check("R2 nvmacc bypass", acc[0], 1536);
      else     check($sformatf("R3 nvmacc div%0d", sd), acc[0], 1536 / s);
      check($sformatf("R4 cpu fac%0d", nf), acc[1], 1536 / l);
      check("R5 pclk", acc[2], 1536 / l);
      check("R5 pclk2", acc[3], 1536 / l);
      check("R5 nvmclk", acc[4], 1536 / l);
      check("R6 comm", acc[5], 1536);
   endtask

   task automatic t_boundary;
      int zeros = 0;
      slow_en = 1'b1; slow_div = 3'd3; nvm_fac = 2'd0;
      step(600);
      do @(negedge clk_ref); while (!en_nvmacc);
      @(posedge clk_ref); #1;
      slow_div = 3'd0;
      for (int i = 1; i < 8; i++) begin
         @(negedge clk_ref);
         zeros += int'(en_nvmacc);
      end
      check("R7 no early pulse", zeros, 0);
      @(negedge clk_ref);
      check("R7 pulse at boundary", int'(en_nvmacc), 1);
      @(negedge clk_ref);
      check("R7 new ratio", int'(en_nvmacc), 1);
      slow_en = 1'b0;
      step(20);
   endtask

   task automatic t_filter;
      filt_pre = 6'd4;
      step(20);
      measure(60);
      check("R10 filt pre4", acc[6], 12);
      filt_pre = 6'd0;
      step(20);
      measure(60);
      check("R10 filt pre0", acc[6], 60);
      check("R11 const cpu", acc[1], 60);
   endtask

   task automatic t_power;
      filt_pre = 6'd1;
      pll_lock = 1'b0;
      pd_req = 1'b1; step(1); pd_req = 1'b0;
      step(20);
      measure(60);
      check("R8 down domains", acc[0] + acc[1] + acc[2] + acc[3] + acc[4] + acc[5], 0);
      check("R8 filt on lowp", acc[6], 6);
      wake_req = 1'b1; step(1); wake_req = 1'b0;
      measure(60);
      check("R9 cpu resumes", acc[1], 60);
      check("R9 pclk2 resumes", acc[3], 60);
      check("R9 nvmclk resumes", acc[4], 60);
      check("R9 pclk waits lock", acc[2], 0);
      pll_lock = 1'b1;
      step(2);
      measure(60);
      check("R9 pclk after lock", acc[2], 60);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_source();
      t_ratio(1'b0, 5, 0);
      t_ratio(1'b1, 2, 0);
      t_ratio(1'b1, 1, 2);
      t_ratio(1'b1, 7, 3);
      t_ratio(1'b0, 7, 1);
      t_boundary();
      t_filter();
      t_power();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_ref);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule